// File: doc/BRIEF.md
# Cursor Register Arming Controller

This block holds the programming registers of a display cursor plane in two copies. Software writes control, position, base address and size words into a pending copy through a plain write strobe. The pending copy reaches the active copy only after the update has been armed, and then only at the start of the next vertical blank. The active copy drives the pixel pipeline, which lies outside this block.

Arming is deliberately asymmetric. A base write arms the update. A control write arms it only when the cursor is currently off. Every other accepted register write withdraws an armed update, so software finishes each sequence with a base write. The `LEGACY` parameter selects an older variant with two differences. Base and size can change only while the cursor is off. Any control write arms the update.

The write port has no back-pressure: every strobe is taken on the clock where it is seen, and there is no ready signal. The vblank input is a level pulse from the timing generator, and only its first clock acts.

Top module: `cursor_arm_top`

## Requirements
- R1: After reset all four active registers are zero, `armed` is 0 and `cursor_on` is 0. Every pending register resets to all ones.
- R2: An accepted write to the base register (address 2) sets `armed` on the next clock.
- R3: A write to the control register (address 0) sets `armed` when the active cursor is off. In the legacy variant it sets `armed` in every case.
- R4: An accepted write that does not arm clears `armed`. Such writes are to position (address 1), to size (address 3), or to control while the cursor is on in the non-legacy variant.
- R5: On the first clock that `vblank` is high after being low, if `armed` is set, all four pending values move to the active registers and `armed` clears. With `armed` clear, or on later clocks of a held pulse, the active registers keep their values.
- R6: `cursor_on` is 1 exactly when the mode field of the active control register (bits 2:0) is non-zero.
- R7: In the legacy variant, writes to base or size while `cursor_on` is 1 are ignored. They change no pending value and do not touch `armed`.
- R8: `act_width` is bits 11:0 of the active size register, and `act_height` is bits 23:12.
- R9: When a write and the first vblank clock fall on the same clock, the transfer uses the pending values from before that write. The written value stays pending, and `armed` follows R2 to R4 for that write.
- R10: Writes to addresses 4 to 7 change nothing: no pending value and no `armed` state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per clock |
| wr_addr | input | ADDR_W (3) | Register address: 0 control, 1 position, 2 base, 3 size |
| wr_data | input | DATA_W (32) | Write data |
| vblank | input | 1 | Vertical blank level; its rising clock is the transfer point |
| act_ctrl | output | DATA_W | Active control register |
| act_pos | output | DATA_W | Active position register |
| act_base | output | DATA_W | Active base register |
| act_size | output | DATA_W | Active size register |
| act_width | output | DIM_W (12) | Width field of the active size |
| act_height | output | DIM_W (12) | Height field of the active size |
| cursor_on | output | 1 | Active mode field is non-zero |
| armed | output | 1 | A pending update is waiting for vblank |

## Verification
On every cycle, the assertions check the `armed` flag against the arm and cancel decisions. They also check that the active registers hold between transfers, that a transfer clears the flag, and that locked base and size writes in the legacy variant leave the pending copy alone. The orderings that only the scenarios can show are the ones where the value moved matters. Examples are a transfer at the same clock as a write, a cancel just before the blank, a held vblank followed by a late arm, and a disable done through the control-then-base sequence. A behavioural model runs on both variants side by side and is compared with them on every clock.

// File: rtl/cursor_arm_pkg.sv
package cursor_arm_pkg;
  localparam int NUM_REGS = 4;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_POS  = 2'd1,
    REG_BASE = 2'd2,
    REG_SIZE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cursor_arm_decode.sv
module cursor_arm_decode
  import cursor_arm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter bit LEGACY = 1'b0
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                act_on,
  output logic [NUM_REGS-1:0] accept,
  output logic                arm_set,
  output logic                arm_clr
);
  logic hit;
  logic lock;
  logic ctrl_arms;

  assign hit = wr_en && (wr_addr < ADDR_W'(NUM_REGS));

  generate
    if (LEGACY) begin : g_legacy
      assign lock      = act_on;
      assign ctrl_arms = 1'b1;
    end else begin : g_plain
      assign lock      = 1'b0;
      assign ctrl_arms = !act_on;
    end
  endgenerate

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_acc
    localparam bit LOCKABLE = (i == int'(REG_BASE)) || (i == int'(REG_SIZE));
    assign accept[i] = hit && (wr_addr[1:0] == 2'(i)) && !(LOCKABLE && lock);
  end

  assign arm_set = accept[REG_BASE] || (accept[REG_CTRL] && ctrl_arms);
  assign arm_clr = (|accept) && !arm_set;

  // R10: unmapped addresses produce no decision
  always_comb begin
    a_r10_unmapped: assert (!(wr_en && wr_addr >= ADDR_W'(NUM_REGS)) || (accept == '0));
  end
endmodule

// File: rtl/cursor_arm_shadow.sv
module cursor_arm_shadow
  import cursor_arm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              accept,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  pend
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend[i] <= '1;
      else if (accept[i]) pend[i] <= wr_data;
    end

    // R7/R10: a pending word moves only on its own accepted write
    a_r7_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !accept[i] |=> $stable(pend[i]));
  end
endmodule

// File: rtl/cursor_arm_active.sv
module cursor_arm_active
  import cursor_arm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             vblank,
  input  logic                             arm_set,
  input  logic                             arm_clr,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  pend,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  act,
  output logic                             armed
);
  logic vb_q;
  logic xfer;

  assign xfer = vblank && !vb_q && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_q  <= 1'b0;
      armed <= 1'b0;
      act   <= '0;
    end else begin
      vb_q <= vblank;
      if (xfer) act <= pend;
      if (arm_set)               armed <= 1'b1;
      else if (arm_clr || xfer)  armed <= 1'b0;
    end
  end

  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set |=> armed);
  a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    arm_clr |=> !armed);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !arm_set) |=> !armed);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(act));
  a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_set && !arm_clr && !xfer) |=> $stable(armed));
endmodule

// File: rtl/cursor_arm_top.sv
module cursor_arm_top
  import cursor_arm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int DIM_W  = 12,
  parameter int MODE_W = 3,
  parameter bit LEGACY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vblank,
  output logic [DATA_W-1:0] act_ctrl,
  output logic [DATA_W-1:0] act_pos,
  output logic [DATA_W-1:0] act_base,
  output logic [DATA_W-1:0] act_size,
  output logic [DIM_W-1:0]  act_width,
  output logic [DIM_W-1:0]  act_height,
  output logic              cursor_on,
  output logic              armed
);
  localparam int HEIGHT_LSB = DIM_W;

  logic [NUM_REGS-1:0]             accept;
  logic                            arm_set;
  logic                            arm_clr;
  logic [NUM_REGS-1:0][DATA_W-1:0] pend;
  logic [NUM_REGS-1:0][DATA_W-1:0] act;

  cursor_arm_decode #(.ADDR_W(ADDR_W), .LEGACY(LEGACY)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .act_on  (cursor_on),
    .accept  (accept),
    .arm_set (arm_set),
    .arm_clr (arm_clr)
  );

  cursor_arm_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .wr_data (wr_data),
    .pend    (pend)
  );

  cursor_arm_active #(.DATA_W(DATA_W)) u_active (
    .clk     (clk),
    .rst_n   (rst_n),
    .vblank  (vblank),
    .arm_set (arm_set),
    .arm_clr (arm_clr),
    .pend    (pend),
    .act     (act),
    .armed   (armed)
  );

  assign act_ctrl   = act[REG_CTRL];
  assign act_pos    = act[REG_POS];
  assign act_base   = act[REG_BASE];
  assign act_size   = act[REG_SIZE];
  assign act_width  = act_size[DIM_W-1:0];
  assign act_height = act_size[HEIGHT_LSB +: DIM_W];
  assign cursor_on  = |act_ctrl[MODE_W-1:0];

  // R7: in the legacy variant a base write while on leaves the pending base alone
  if (LEGACY) begin : g_lock_chk
    a_r7_locked_base: assert property (@(posedge clk) disable iff (!rst_n)
      (cursor_on && wr_en && wr_addr == ADDR_W'(REG_BASE)) |=> $stable(pend[REG_BASE]));
  end
endmodule

// File: tb/test_cursor_arm_top.sv
module test_cursor_arm_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        vblank = 1'b0;

  logic [31:0] o_ctrl[2], o_pos[2], o_base[2], o_size[2];
  logic [11:0] o_w[2], o_h[2];
  logic        o_on[2], o_armed[2];

  int tests = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_arm_top i_cursor_arm_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vblank(vblank), .act_ctrl(o_ctrl[0]), .act_pos(o_pos[0]), .act_base(o_base[0]),
    .act_size(o_size[0]), .act_width(o_w[0]), .act_height(o_h[0]),
    .cursor_on(o_on[0]), .armed(o_armed[0]));

  cursor_arm_top #(.LEGACY(1'b1)) i_cursor_arm_top_legacy (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vblank(vblank), .act_ctrl(o_ctrl[1]), .act_pos(o_pos[1]), .act_base(o_base[1]),
    .act_size(o_size[1]), .act_width(o_w[1]), .act_height(o_h[1]),
    .cursor_on(o_on[1]), .armed(o_armed[1]));

  // behavioural reference: [variant][reg]
  logic [31:0] m_pend[2][4];
  logic [31:0] m_act[2][4];
  bit          m_armed[2];
  bit          m_vbq;

  task automatic model_reset();
    for (int v = 0; v < 2; v++) begin
      for (int r = 0; r < 4; r++) begin
        m_pend[v][r] = '1;
        m_act[v][r]  = '0;
      end
      m_armed[v] = 0;
    end
    m_vbq = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int v = 0; v < 2; v++) begin
        bit on, xfer, acc, arms;
        int sel;
        on   = m_act[v][0][2:0] != 0;
        xfer = vblank && !m_vbq && m_armed[v];
        if (xfer) for (int r = 0; r < 4; r++) m_act[v][r] = m_pend[v][r];
        acc = 0; arms = 0; sel = wr_addr;
        if (wr_en && wr_addr < 4) begin
          acc = !(v == 1 && on && (sel == 2 || sel == 3));
          if (acc) m_pend[v][sel] = wr_data;
          arms = acc && (sel == 2 || (sel == 0 && (v == 1 || !on)));
        end
        if (arms) m_armed[v] = 1;
        else if (acc || xfer) m_armed[v] = 0;
      end
      m_vbq = vblank;
    end
  end

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      for (int v = 0; v < 2; v++) begin
        chk(o_ctrl[v] === m_act[v][0], $sformatf("v%0d ctrl", v), o_ctrl[v], m_act[v][0]);
        chk(o_pos[v]  === m_act[v][1], $sformatf("v%0d pos", v),  o_pos[v],  m_act[v][1]);
        chk(o_base[v] === m_act[v][2], $sformatf("v%0d base", v), o_base[v], m_act[v][2]);
        chk(o_size[v] === m_act[v][3], $sformatf("v%0d size", v), o_size[v], m_act[v][3]);
        chk(o_w[v] === m_act[v][3][11:0], $sformatf("R8 v%0d width", v),
            32'(o_w[v]), 32'(m_act[v][3][11:0]));
        chk(o_h[v] === m_act[v][3][23:12], $sformatf("R8 v%0d height", v),
            32'(o_h[v]), 32'(m_act[v][3][23:12]));
        chk(o_on[v] === (m_act[v][0][2:0] != 0), $sformatf("R6 v%0d on", v),
            32'(o_on[v]), 32'(m_act[v][0][2:0] != 0));
        chk(o_armed[v] === m_armed[v], $sformatf("v%0d armed", v),
            32'(o_armed[v]), 32'(m_armed[v]));
      end
    end
    if (cycles > WATCHDOG) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic vb(int n);
    @(negedge clk); vblank = 1;
    repeat (n) @(negedge clk);
    vblank = 0;
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    cur_req = "R1";
    @(negedge clk);
    chk(o_ctrl[0] == 0 && !o_armed[0] && !o_on[0], "R1 reset state", o_ctrl[0], 0);
    cur_req = "R3"; wr(0, 32'h1);          // enable while off arms
    chk(o_armed[0] && o_armed[1], "R3 ctrl arms while off", 32'(o_armed[0]), 1);
    cur_req = "R5"; vb(1); idle(1);
    chk(o_on[0] && o_ctrl[0] == 1, "R5 transfer enables", o_ctrl[0], 1);
    cur_req = "R2"; wr(1, 32'h0010_0020); wr(2, 32'hA000);
    chk(o_armed[0], "R2 base arms", 32'(o_armed[0]), 1);
    vb(2); idle(1);
    cur_req = "R4"; wr(2, 32'hB000); wr(1, 32'h5);
    chk(!o_armed[0], "R4 pos cancels", 32'(o_armed[0]), 0);
    vb(1); idle(1);
    wr(2, 32'hB100); wr(3, 32'h0004_0040); vb(1); idle(1);
    wr(2, 32'hB200); wr(0, 32'h2); vb(1); idle(1);   // ctrl while on: cancels / legacy arms
    cur_req = "R7"; wr(2, 32'hC000); wr(3, 32'h0020_0020); wr(0, 32'h3); vb(1); idle(1);
    cur_req = "R5"; vblank = 1; idle(2); wr(2, 32'hD000); idle(3); vblank = 0; idle(2);
    vb(1); idle(1);
    cur_req = "R8"; wr(0, 32'h0); wr(3, 32'h0030_0040); wr(2, 32'hE000); vb(1); idle(1);
    wr(0, 32'h1); vb(1); idle(1);
    cur_req = "R9"; wr(2, 32'hF000);
    @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = 32'h77; vblank = 1;
    @(negedge clk); wr_en = 0; vblank = 0; idle(2);
    wr(0, 32'h0); wr(2, 32'hF100);
    @(negedge clk); wr_en = 1; wr_addr = 2; wr_data = 32'hF200; vblank = 1;
    @(negedge clk); wr_en = 0; vblank = 0; idle(1);
    chk(o_armed[0], "R9 write wins armed", 32'(o_armed[0]), 1);
    cur_req = "R10"; wr(5, 32'h1234); wr(7, 32'h0);
    chk(o_armed[0], "R10 unmapped keeps armed", 32'(o_armed[0]), 1);
    vb(1); idle(2);
    chk(o_base[0] == 32'hF200, "R10 base after unmapped", o_base[0], 32'hF200);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule